// File: doc/BRIEF.md
# Nibble Bus Master Sequencer

This block is the host end of a multiplexed 4-bit bus on which every address, command and data nibble shares the same four lines. It turns one simple request into the strobe and command/data traffic the bus expects. The request can be a read or write of 1 to 16 nibbles at a 20-bit address through either the program-counter or the data-pointer channel, a service poll, a shutdown or a bus-wide reset. Read nibbles come back one per cycle on a result port. A done pulse marks the end of each request.

Each bus strobe takes two clock cycles. In the first cycle the strobe is high, and the command/data line and the bus nibble are set up. In the second cycle the strobe is low. The slaves latch on the rising strobe at the end of that second cycle. A read at a new address carries no command after the five address nibbles: the slaves turn the address load into a read on their own. A write sends an explicit write command after the address. While read data is expected, the master drives the bus low in the setup cycle and lets it go while the strobe is low, so lines that no device drives read as zero.

A shutdown request puts the block in standby. In standby the strobe stays high and the command/data line is released. A key input going high, or any device pulling command/data low, wakes the block. It then sends a NOP command and a program-counter load of the current program counter before it takes new requests.

Top module: `nbm_bus_master`

## Requirements
- R1: After reset the outputs are as follows. `str_n`=1, `cd_n`=1, `cd_oe`=1, `bus_oe`=0, `req_ready`=1, `standby`=0, `rd_valid`=0 and `done`=0.
- R2: Each strobe is one cycle with `str_n` high, in which `cd_n` and the nibble are set up, followed by exactly one cycle with `str_n` low and `cd_n` unchanged. `str_n` is never low in two consecutive cycles.
- R3: A read (`req_op`=0) sends these strobes in order:
  - one command strobe (`cd_n`=0) carrying 6 when `req_dp`=0 or 7 when `req_dp`=1;
  - five address strobes (`cd_n`=1), lowest nibble of `req_addr` first;
  - L data strobes (`cd_n`=1), with no further command.
  
  `done` is high in the cycle that follows the 2·(6+L)-th clock edge after acceptance.
- R4: A write (`req_op`=1) sends these strobes in order:
  - the same load command and five address strobes as a read;
  - a command strobe carrying 4 when `req_dp`=0 or 5 when `req_dp`=1;
  - L data strobes, where data strobe i carries `req_wdata[4i+3:4i]`.
  
  `done` follows 2·(7+L) edges after acceptance.
- R5: The transfer length is L = `req_lenm1`+1, so 1 to 16 nibbles per request.
- R6: For every read data strobe, `rd_valid` is high for one cycle, in the cycle after the strobe's low cycle. `rd_nib` holds the value of `bus_in` at the end of that low cycle. Nibbles arrive in bus order.
- R7: In every read data strobe, the setup cycle drives the bus with `bus_oe`=1 and `bus_out`=0. The strobe-low cycle has `bus_oe`=0.
- R8: A poll (`req_op`=2) sends command 0xA and then one read data strobe. The single returned nibble is the OR of all responders. `done` follows 4 edges after acceptance.
- R9: A reset request (`req_op`=4, also any code from 5 to 7) sends the single command 0xF. `done` follows 2 edges after acceptance.
- R10: A shutdown (`req_op`=3) sends the command 0xE, pulses `done` after 2 edges, and then holds standby. In standby, `standby`=1, `str_n` stays high, `cd_oe`=0 and `req_ready`=0. `req_valid` is ignored.
- R11: In standby, `key_in`=1 or `cd_in`=0 at a clock edge starts wake-up. Wake-up sends command 0x0, then command 6, then five strobes with `cur_pc` lowest nibble first. `req_ready` returns after 14 edges, and `done` is not pulsed.
- R12: While idle, no strobe occurs and `key_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_op | input | 3 | 0 read, 1 write, 2 poll, 3 shutdown, 4 reset |
| req_dp | input | 1 | 1 selects the data-pointer channel, 0 the program counter |
| req_addr | input | 20 | Start address |
| req_lenm1 | input | 4 | Transfer length minus one |
| req_wdata | input | 64 | Write nibbles, nibble i in bits 4i+3..4i |
| req_ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle pulse at the end of a request |
| cur_pc | input | 20 | Program counter sent on wake-up |
| key_in | input | 1 | Key wake source |
| cd_in | input | 1 | Sensed level of the command/data line |
| bus_in | input | 4 | Sensed bus nibble |
| str_n | output | 1 | Bus strobe, active low |
| cd_n | output | 1 | Command/data: 0 command, 1 data |
| cd_oe | output | 1 | Drive enable for `cd_n` |
| bus_out | output | 4 | Bus nibble driven by the master |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| rd_valid | output | 1 | Read nibble valid |
| rd_nib | output | 4 | Read nibble |
| standby | output | 1 | Block is in standby |

## Verification
Every result is due at a fixed cycle offset that the bench derives from the strobe count. With n strobes in a request, `done` appears in the cycle after the 2n-th edge following acceptance. Read nibble k appears in the cycle after the low cycle of its strobe. Wake-up returns `req_ready` 14 edges after the wake edge.

The bench counts edges from acceptance and compares the count exactly. It samples every output on the falling clock. A slave model in the bench acts on each strobe only after the master has captured the bus, so the returned nibbles follow its own address pointers rather than any copy of the design.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_POLL  = 3'd2,
    OP_SHUT  = 3'd3,
    OP_RESET = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WCMD, S_DATA,
    S_STBY, S_WNOP, S_WLD, S_WADDR
  } st_e;

  localparam logic [3:0] CMD_NOP   = 4'h0;
  localparam logic [3:0] CMD_WR_PC = 4'h4;
  localparam logic [3:0] CMD_WR_DP = 4'h5;
  localparam logic [3:0] CMD_LD_PC = 4'h6;
  localparam logic [3:0] CMD_LD_DP = 4'h7;
  localparam logic [3:0] CMD_POLL  = 4'hA;
  localparam logic [3:0] CMD_SHUT  = 4'hE;
  localparam logic [3:0] CMD_RST   = 4'hF;

  function automatic logic [3:0] load_code(input logic dp);
    return dp ? CMD_LD_DP : CMD_LD_PC;
  endfunction

  function automatic logic [3:0] write_code(input logic dp);
    return dp ? CMD_WR_DP : CMD_WR_PC;
  endfunction

  // first command of a request
  function automatic logic [3:0] head_code(input op_e op, input logic dp);
    case (op)
      OP_READ, OP_WRITE: return load_code(dp);
      OP_POLL:           return CMD_POLL;
      OP_SHUT:           return CMD_SHUT;
      default:           return CMD_RST;
    endcase
  endfunction

  // number of strobes a request produces (for bench and notes)
  function automatic int unsigned strobe_count(input op_e op, input int unsigned len);
    case (op)
      OP_READ:  return 6 + len;
      OP_WRITE: return 7 + len;
      OP_POLL:  return 2;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/nbm_phase.sv
// Two-phase strobe generator: setup cycle then strobe-low cycle.
module nbm_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= run & ~ph;
  end
endmodule

// File: rtl/nbm_rdcap.sv
// Captures the bus at the end of each read strobe.
module nbm_rdcap #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [NIB_W-1:0] bus_in,
  output logic             rd_valid,
  output logic [NIB_W-1:0] rd_nib
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_nib   <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_nib <= bus_in;
    end
  end
endmodule

// File: rtl/nbm_seq.sv
// Request sequencer: expands requests into command/address/data strobes.
module nbm_seq
  import nbm_pkg::*;
#(
  parameter int LEN_MAX = 16,
  parameter int ADDR_W  = 20,
  parameter int LEN_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ph,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic                 req_dp,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_lenm1,
  input  logic [LEN_MAX*4-1:0] req_wdata,
  input  logic [ADDR_W-1:0]    cur_pc,
  input  logic                 wake,
  output logic                 run,
  output logic                 slot_end,
  output logic                 rd_slot,
  output logic                 cd_n,
  output logic                 bus_oe,
  output logic [3:0]           bus_out,
  output logic                 done,
  output logic                 ready,
  output logic                 standby
);
  localparam int ANIB  = ADDR_W / 4;
  localparam int CNT_W = (LEN_W > 3) ? LEN_W : 3;
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(ANIB - 1);

  st_e                  st, nxt;
  op_e                  op_q;
  logic                 dp_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [LEN_W-1:0]     len_q;
  logic [LEN_MAX*4-1:0] wd_q;
  logic [CNT_W-1:0]     cnt, cnt_n;
  logic                 fin;
  logic [CNT_W+1:0]     bit_ix;

  assign bit_ix   = {cnt, 2'b00};
  assign run      = (st != S_IDLE) && (st != S_STBY);
  assign slot_end = run & ph;
  assign ready    = (st == S_IDLE);
  assign standby  = (st == S_STBY);

  // slot sequencing
  always_comb begin
    nxt   = st;
    cnt_n = cnt + 1'b1;
    fin   = 1'b0;
    case (st)
      S_CMD: begin
        cnt_n = '0;
        case (op_q)
          OP_READ, OP_WRITE: nxt = S_ADDR;
          OP_POLL:           nxt = S_DATA;
          OP_SHUT:           begin nxt = S_STBY; fin = 1'b1; end
          default:           begin nxt = S_IDLE; fin = 1'b1; end
        endcase
      end
      S_ADDR: if (cnt == LAST_A) begin
        cnt_n = '0;
        nxt   = (op_q == OP_WRITE) ? S_WCMD : S_DATA;
      end
      S_WCMD:  begin nxt = S_DATA; cnt_n = '0; end
      S_DATA:  if (cnt == CNT_W'(len_q)) begin
        nxt = S_IDLE; cnt_n = '0; fin = 1'b1;
      end
      S_WNOP:  begin nxt = S_WLD;   cnt_n = '0; end
      S_WLD:   begin nxt = S_WADDR; cnt_n = '0; end
      S_WADDR: if (cnt == LAST_A) begin
        nxt = S_IDLE; cnt_n = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_READ;
      dp_q   <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      wd_q   <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_CMD;
          op_q   <= op_e'(req_op);
          dp_q   <= req_dp;
          addr_q <= req_addr;
          len_q  <= (op_e'(req_op) == OP_POLL) ? '0 : req_lenm1;
          wd_q   <= req_wdata;
          cnt    <= '0;
        end
        S_STBY: if (wake) begin
          st     <= S_WNOP;
          addr_q <= cur_pc;
          cnt    <= '0;
        end
        default: if (slot_end) begin
          st   <= nxt;
          cnt  <= cnt_n;
          done <= fin;
        end
      endcase
    end
  end

  // bus drive per slot
  always_comb begin
    cd_n    = 1'b1;
    bus_oe  = 1'b0;
    bus_out = '0;
    rd_slot = 1'b0;
    case (st)
      S_CMD:   begin cd_n = 1'b0; bus_oe = 1'b1; bus_out = head_code(op_q, dp_q); end
      S_ADDR:  begin bus_oe = 1'b1; bus_out = addr_q[bit_ix +: 4]; end
      S_WCMD:  begin cd_n = 1'b0; bus_oe = 1'b1; bus_out = write_code(dp_q); end
      S_DATA: begin
        if (op_q == OP_WRITE) begin
          bus_oe  = 1'b1;
          bus_out = wd_q[bit_ix +: 4];
        end else begin
          rd_slot = 1'b1;
          bus_oe  = ~ph;          // precharge low, then release
        end
      end
      S_WNOP:  begin cd_n = 1'b0; bus_oe = 1'b1; bus_out = CMD_NOP; end
      S_WLD:   begin cd_n = 1'b0; bus_oe = 1'b1; bus_out = CMD_LD_PC; end
      S_WADDR: begin bus_oe = 1'b1; bus_out = addr_q[bit_ix +: 4]; end
      default: ;
    endcase
  end

endmodule

// File: rtl/nbm_bus_master.sv
module nbm_bus_master #(
  parameter int LEN_MAX = 16,
  parameter int ADDR_W  = 20,
  localparam int LEN_W  = $clog2(LEN_MAX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic                 req_dp,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_lenm1,
  input  logic [LEN_MAX*4-1:0] req_wdata,
  output logic                 req_ready,
  output logic                 done,
  input  logic [ADDR_W-1:0]    cur_pc,
  input  logic                 key_in,
  input  logic                 cd_in,
  input  logic [3:0]           bus_in,
  output logic                 str_n,
  output logic                 cd_n,
  output logic                 cd_oe,
  output logic [3:0]           bus_out,
  output logic                 bus_oe,
  output logic                 rd_valid,
  output logic [3:0]           rd_nib,
  output logic                 standby
);
  // named internal events
  logic ph, run, slot_end, rd_slot, cap_en, wake;

  assign wake   = key_in | ~cd_in;
  assign cap_en = slot_end & rd_slot;
  assign str_n  = ~slot_end;
  assign cd_oe  = ~standby;

  nbm_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .ph(ph)
  );

  nbm_seq #(.LEN_MAX(LEN_MAX), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ph(ph),
    .req_valid(req_valid), .req_op(req_op), .req_dp(req_dp),
    .req_addr(req_addr), .req_lenm1(req_lenm1), .req_wdata(req_wdata),
    .cur_pc(cur_pc), .wake(wake),
    .run(run), .slot_end(slot_end), .rd_slot(rd_slot),
    .cd_n(cd_n), .bus_oe(bus_oe), .bus_out(bus_out),
    .done(done), .ready(req_ready), .standby(standby)
  );

  nbm_rdcap #(.NIB_W(4)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .bus_in(bus_in),
    .rd_valid(rd_valid), .rd_nib(rd_nib)
  );

endmodule

// File: rtl/nbm_checker.sv
module nbm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       str_n,
  input logic       cd_n,
  input logic       cd_oe,
  input logic       bus_oe,
  input logic [3:0] bus_out,
  input logic       rd_valid,
  input logic       req_ready,
  input logic       standby
);
  assert_single_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !str_n |=> str_n);

  assert_setup_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(str_n) |-> $stable(cd_n));

  assert_cmd_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!str_n && !cd_n) |-> bus_oe);

  assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(str_n) && !bus_oe) |-> ($past(bus_oe) && ($past(bus_out) == 4'h0)));

  assert_rd_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!str_n) && $past(!bus_oe)));

  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (str_n && !cd_oe && !req_ready));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (str_n && !bus_oe));
endmodule

bind nbm_bus_master nbm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .str_n(str_n), .cd_n(cd_n), .cd_oe(cd_oe),
  .bus_oe(bus_oe), .bus_out(bus_out), .rd_valid(rd_valid),
  .req_ready(req_ready), .standby(standby)
);

// File: tb/nbm_bus_master_tb_top.sv
module nbm_bus_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic        req_dp = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_lenm1 = '0;
  logic [63:0] req_wdata = '0;
  logic [19:0] cur_pc = '0;
  logic        key_in = 1'b0;
  logic        ext_cd_low = 1'b0;
  logic        req_ready, done, str_n, cd_n, cd_oe, bus_oe, rd_valid, standby;
  logic [3:0]  bus_out, rd_nib, bus_in, model_out;
  logic        cd_in;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;   // 50 MHz

  nbm_bus_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_dp(req_dp), .req_addr(req_addr), .req_lenm1(req_lenm1),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .cur_pc(cur_pc), .key_in(key_in), .cd_in(cd_in), .bus_in(bus_in),
    .str_n(str_n), .cd_n(cd_n), .cd_oe(cd_oe), .bus_out(bus_out),
    .bus_oe(bus_oe), .rd_valid(rd_valid), .rd_nib(rd_nib), .standby(standby)
  );

  // ---------------- slave model ----------------
  logic [3:0]  smem [64];
  logic [3:0]  em   [64];
  logic [3:0]  s_cmd = 4'h0;
  logic [19:0] s_pc = '0, s_dp = '0;
  int          s_cnt = 0;
  logic [3:0]  poll_resp = 4'h5;
  logic        pend = 1'b0, pcd = 1'b1;
  logic [3:0]  pnib = '0;
  logic [4:0]  slog [64];
  int          lcnt = 0, rcnt = 0, done_cnt = 0, prech_seen = 0, prech_bad = 0;
  logic [3:0]  rbuf [32];
  logic        prev_oe = 1'b0;
  logic [3:0]  prev_out = '0;

  initial for (int i = 0; i < 64; i++) begin
    smem[i] = 4'((i * 5 + 3) % 16);
    em[i]   = 4'((i * 5 + 3) % 16);
  end

  assign model_out = (s_cmd == 4'h2) ? smem[s_pc[5:0]] :
                     (s_cmd == 4'h3) ? smem[s_dp[5:0]] :
                     (s_cmd == 4'hA) ? poll_resp : 4'h0;
  assign bus_in = bus_oe ? bus_out : model_out;
  assign cd_in  = ext_cd_low ? 1'b0 : (cd_oe ? cd_n : 1'b1);

  always @(negedge clk) begin
    if (pend) begin
      pend = 1'b0;
      if (!pcd) begin
        s_cmd = pnib; s_cnt = 0;
      end else begin
        case (s_cmd)
          4'h6: begin s_pc[s_cnt*4 +: 4] = pnib; s_cnt++; if (s_cnt == 5) s_cmd = 4'h2; end
          4'h7: begin s_dp[s_cnt*4 +: 4] = pnib; s_cnt++; if (s_cnt == 5) s_cmd = 4'h3; end
          4'h2: s_pc++;
          4'h3: s_dp++;
          4'h4: begin smem[s_pc[5:0]] = pnib; s_pc++; end
          4'h5: begin smem[s_dp[5:0]] = pnib; s_dp++; end
          default: ;
        endcase
      end
    end
    if (rst_n && !str_n) begin
      pend = 1'b1; pcd = cd_n; pnib = bus_in;
      if (lcnt < 64) slog[lcnt] = {cd_n, bus_in};
      lcnt++;
      if (!bus_oe) begin
        prech_seen++;
        if (!(prev_oe && prev_out == 4'h0)) prech_bad++;
      end
    end
    if (rst_n && rd_valid) begin
      if (rcnt < 32) rbuf[rcnt] = rd_nib;
      rcnt++;
    end
    if (rst_n && done) done_cnt++;
    prev_oe  = bus_oe;
    prev_out = bus_out;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {care_nibble, cd_n, nibble}
  function automatic logic [5:0] exp_ent(input logic [2:0] op, input logic dp,
      input logic [19:0] addr, input logic [63:0] wd, input int k);
    if (op == 3'd2) return (k == 0) ? 6'b10_1010 : 6'b01_0000;
    if (op > 3'd2) return {2'b10, (op == 3'd3) ? 4'hE : 4'hF};
    if (k == 0) return {2'b10, dp ? 4'h7 : 4'h6};
    if (k <= 5) return {2'b11, addr[(k-1)*4 +: 4]};
    if (op == 3'd0) return 6'b01_0000;
    if (k == 6) return {2'b10, dp ? 4'h5 : 4'h4};
    return {2'b11, wd[(k-7)*4 +: 4]};
  endfunction

  task automatic run_req(input logic [2:0] op, input logic dp, input logic [19:0] addr,
      input logic [3:0] lenm1, input logic [63:0] wd, input string tag);
    int n, cyc, len;
    len = int'(lenm1) + 1;
    n = (op == 3'd0) ? 6 + len : (op == 3'd1) ? 7 + len : (op == 3'd2) ? 2 : 1;
    @(negedge clk);
    lcnt = 0; rcnt = 0;
    req_valid = 1'b1; req_op = op; req_dp = dp; req_addr = addr;
    req_lenm1 = lenm1; req_wdata = wd;
    @(posedge clk);
    cyc = 0;
    while (cyc < 400) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done) break;
      @(posedge clk);
      cyc++;
    end
    // R3 R4 R8 R9 R10: completion timing
    chk(cyc == 2 * n, {tag, " R3/R4 done timing"}, cyc, 2 * n);
    @(posedge clk); @(negedge clk);
    chk(lcnt == n, {tag, " strobe count R3"}, lcnt, n);
    for (int k = 0; k < n && k < 64; k++) begin
      logic [5:0] e;
      e = exp_ent(op, dp, addr, wd, k);
      if (e[5]) chk(slog[k] == e[4:0], {tag, " strobe content R3 R4"}, slog[k], e[4:0]);
      else      chk(slog[k][4] == e[4], {tag, " data strobe cd R3"}, slog[k][4], e[4]);
    end
    if (op == 3'd0) begin
      chk(rcnt == len, {tag, " R6 read count"}, rcnt, len);
      for (int i = 0; i < len; i++)
        chk(rbuf[i] == em[(addr[5:0] + i) % 64], {tag, " R6 read data"},
            rbuf[i], em[(addr[5:0] + i) % 64]);
    end
    if (op == 3'd2) begin
      chk(rcnt == 1, {tag, " R8 poll count"}, rcnt, 1);
      chk(rbuf[0] == poll_resp, {tag, " R8 poll value"}, rbuf[0], poll_resp);
    end
    if (op == 3'd1)
      for (int i = 0; i < len; i++) em[(addr[5:0] + i) % 64] = wd[i*4 +: 4];
  endtask

  task automatic wake_check(input bit by_key, input logic [19:0] pc, input string tag);
    int cyc, d0;
    logic [4:0] e;
    d0 = done_cnt;
    @(negedge clk);
    lcnt = 0; cur_pc = pc;
    if (by_key) key_in = 1'b1; else ext_cd_low = 1'b1;
    @(posedge clk);
    cyc = 0;
    while (cyc < 400) begin
      @(negedge clk);
      key_in = 1'b0; ext_cd_low = 1'b0;
      if (req_ready) break;
      @(posedge clk);
      cyc++;
    end
    chk(cyc == 14, {tag, " R11 wake timing"}, cyc, 14);
    @(posedge clk); @(negedge clk);
    chk(lcnt == 7, {tag, " R11 wake strobes"}, lcnt, 7);
    for (int k = 0; k < 7; k++) begin
      e = (k == 0) ? 5'b0_0000 : (k == 1) ? 5'b0_0110 : {1'b1, pc[(k-2)*4 +: 4]};
      chk(slog[k] == e, {tag, " R11 wake sequence"}, slog[k], e);
    end
    chk(s_pc == pc, {tag, " R11 slave pc loaded"}, s_pc, pc);
    chk(done_cnt == d0, {tag, " R11 no done on wake"}, done_cnt, d0);
    chk(standby == 1'b0, {tag, " R11 standby cleared"}, standby, 0);
  endtask

  // op, dp, addr, lenm1, wdata
  localparam logic [91:0] VEC [8] = '{
    {3'd1, 1'b0, 20'h00010, 4'd3,  64'h0000_0000_0000_A5C3},
    {3'd0, 1'b0, 20'h00010, 4'd3,  64'h0},
    {3'd0, 1'b1, 20'h0003E, 4'd2,  64'h0},
    {3'd1, 1'b1, 20'h12345, 4'd15, 64'hFEDC_BA98_7654_3210},
    {3'd0, 1'b1, 20'h12345, 4'd15, 64'h0},
    {3'd0, 1'b0, 20'h00000, 4'd0,  64'h0},
    {3'd2, 1'b0, 20'h00000, 4'd0,  64'h0},
    {3'd4, 1'b0, 20'h00000, 4'd0,  64'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({str_n, cd_n, cd_oe, bus_oe, req_ready, standby, rd_valid, done} == 8'b1110_1000,
        "R1 reset outputs",
        {str_n, cd_n, cd_oe, bus_oe, req_ready, standby, rd_valid, done}, 8'b1110_1000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++)
      run_req(VEC[v][91:89], VEC[v][88], VEC[v][87:68], VEC[v][67:64], VEC[v][63:0],
              $sformatf("vec%0d", v));

    // R5 longest / shortest covered by vec4 and vec5; R9 by vec7
    // R7 precharge on all read strobes
    chk(prech_seen > 0 && prech_bad == 0, "R7 precharge", prech_bad, 0);

    // R12 idle with key activity
    @(negedge clk);
    lcnt = 0; key_in = 1'b1;
    repeat (30) @(negedge clk);
    key_in = 1'b0;
    chk(lcnt == 0 && !standby && req_ready, "R12 idle quiet", lcnt, 0);

    // R10 shutdown and standby
    run_req(3'd3, 1'b0, 20'h0, 4'd0, 64'h0, "shut1");
    chk(standby && !cd_oe && !req_ready, "R10 standby outputs",
        {standby, cd_oe, req_ready}, 3'b100);
    @(negedge clk);
    lcnt = 0; req_valid = 1'b1; req_op = 3'd0;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    chk(lcnt == 0 && standby, "R10 request ignored in standby", lcnt, 0);

    wake_check(1'b1, 20'hABCDE, "key");
    run_req(3'd0, 1'b0, 20'h00010, 4'd1, 64'h0, "after_wake");
    run_req(3'd3, 1'b0, 20'h0, 4'd0, 64'h0, "shut2");
    wake_check(1'b0, 20'h13579, "cdlow");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule